// File: doc/BRIEF.md
# Host Register File with Interrupt Status

This block is the host-side register front end of a serial bus terminal. A host processor reaches it through a 5-bit register address, a 16-bit data path and separate read and write strobes. It keeps the interrupt enable mask, the configuration, control and test registers, and a collection of interrupt events. The protocol engine supplies event pulses and the current command stack pointer. It takes back single-cycle command pulses and the mask.

One address has two meanings. A write there is decoded as a command word whose bits leave the block as one-cycle pulses: soft reset, start, interrupt clear, time-tag clear, stop after the current message, and stop after the current frame. A read from the same address returns the stack pointer that the engine supplies. Each event whose mask bit is set is latched into a status register. That register uses the mask's bit positions and adds a summary bit in its top position, and the summary bit drives the host interrupt line. A single read therefore tells the host which events are pending and whether any is pending.

Top module: `term_host_regs`

## Requirements
- R1: After reset, irq_o is 0, cmd_o is 0, rdata_o is 0, and every storage register reads 0.
- R2: Storage registers are at addresses 0x00-0x02, 0x04, 0x05, 0x07-0x0F and test addresses 0x10-0x17. A write stores wdata_i, and a later read returns it. The mask at 0x00 keeps only bits 14:0, so its bit 15 reads 0.
- R3: A write to 0x03 drives cmd_o = wdata_i[5:0] for exactly the one cycle after the write edge, and cmd_o is 0 at all other times. The bits are 0 soft reset, 1 start, 2 interrupt clear, 3 time-tag clear, 4 stop at end of message and 5 stop at end of frame.
- R4: A read of 0x03 returns stk_ptr_i. A write to 0x03 changes no storage register.
- R5: Writes to reserved addresses 0x18-0x1F are ignored, and reads from them return 0.
- R6: An event pulse on evt_i[k] with mask bit k set latches status bit k. An event whose mask bit is clear latches nothing.
- R7: A read of 0x06 returns the latched status in bits 14:0 and their OR in bit 15. Writes to 0x06 are ignored.
- R8: irq_o equals the status summary bit and rises in the cycle after the edge that latches an enabled event.
- R9: An interrupt-clear command clears all status bits and irq_o at its write edge. An enabled event that arrives on that same edge is still latched.
- R10: rdata_o is loaded on each edge where rd_i is high and holds at all other times. A read and a write to the same address in one cycle return the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Registered read data |
| stk_ptr_i | input | 16 | Command stack pointer from the engine |
| evt_i | input | 15 | Event pulses from the engine |
| mask_o | output | 15 | Current interrupt mask |
| cmd_o | output | 6 | One-cycle command pulses |
| irq_o | output | 1 | Host interrupt request |

## Verification
The sharpest case is an interrupt-clear command arriving on the same edge as a new enabled event. The bench first leaves an older status bit pending. It then writes the clear command and drives a different event in one cycle. The status read must show only the new bit plus the summary bit, and irq_o must remain high. A second case places a read and a write to the same register in one cycle, and the bench expects the old contents.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam logic [4:0] ADR_MASK = 5'h00;
  localparam logic [4:0] ADR_CMD  = 5'h03;
  localparam logic [4:0] ADR_STAT = 5'h06;

  localparam int CMD_W       = 6;
  localparam int CMD_SRST    = 0;
  localparam int CMD_START   = 1;
  localparam int CMD_IRQ_CLR = 2;
  localparam int CMD_TAG_CLR = 3;
  localparam int CMD_STOP_M  = 4;
  localparam int CMD_STOP_F  = 5;
endpackage

// File: rtl/thr_decode.sv
module thr_decode
  import thr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int N_OPS  = 16,
  parameter int N_TEST = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              is_cmd_o,
  output logic              is_stat_o,
  output logic              is_store_o,
  output logic              is_rsvd_o
);
  localparam int N_LOC = N_OPS + N_TEST;

  logic in_map;

  always_comb begin
    in_map     = (int'(addr_i) < N_LOC);
    is_cmd_o   = (addr_i == ADDR_W'(ADR_CMD));
    is_stat_o  = (addr_i == ADDR_W'(ADR_STAT));
    is_store_o = in_map && !is_cmd_o && !is_stat_o;
    is_rsvd_o  = !in_map;
  end
endmodule

// File: rtl/thr_bank.sv
module thr_bank
  import thr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int EVT_N  = 15,
  parameter int N_LOC  = 24
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [N_LOC-1:0][DATA_W-1:0]   q_o
);
  for (genvar g = 0; g < N_LOC; g++) begin : g_loc
    if (g == int'(ADR_CMD) || g == int'(ADR_STAT)) begin : g_hole
      assign q_o[g] = '0;
    end else begin : g_reg
      // mask keeps only event positions
      localparam int KEEP = (g == int'(ADR_MASK)) ? EVT_N : DATA_W;
      logic [KEEP-1:0] r_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  r_q <= '0;
        else if (we_i && addr_i == ADDR_W'(g))        r_q <= wdata_i[KEEP-1:0];
      end
      assign q_o[g] = DATA_W'(r_q);
    end
  end
endmodule

// File: rtl/thr_cmd.sv
module thr_cmd
  import thr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [CMD_W-1:0] bits_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic             irq_clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_o <= '0;
    else if (fire_i) cmd_o <= bits_i;
    else             cmd_o <= '0;
  end

  // clear acts on the write edge itself
  assign irq_clr_o = fire_i && bits_i[CMD_IRQ_CLR];

  assert_cmd_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != '0) |-> $past(fire_i));

  assert_cmd_once_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != '0 && !fire_i) |=> (cmd_o == '0));
endmodule

// File: rtl/thr_irq.sv
module thr_irq #(
  parameter int EVT_N = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_N-1:0] evt_i,
  input  logic [EVT_N-1:0] mask_i,
  input  logic             clr_i,
  output logic [EVT_N-1:0] pend_o,
  output logic             irq_o
);
  logic [EVT_N-1:0] pend_d;

  always_comb begin
    pend_d = clr_i ? '0 : pend_o;
    pend_d = pend_d | (evt_i & mask_i);  // new events survive a clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      pend_o <= pend_d;
      irq_o  <= |pend_d;
    end
  end

  assert_latch_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_o & ~$past(pend_o)) != '0) |-> ($past(evt_i & mask_i) != '0));

  assert_irq_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(evt_i & mask_i) != '0));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr_i) && $past(evt_i & mask_i) == '0) |-> (pend_o == '0 && !irq_o));
endmodule

// File: rtl/term_host_regs.sv
module term_host_regs
  import thr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int EVT_N  = 15,
  parameter int N_OPS  = 16,
  parameter int N_TEST = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] stk_ptr_i,
  input  logic [EVT_N-1:0]  evt_i,
  output logic [EVT_N-1:0]  mask_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              irq_o
);
  localparam int N_LOC = N_OPS + N_TEST;

  logic is_cmd, is_stat, is_store, is_rsvd;
  logic irq_clr;
  logic [EVT_N-1:0] pend;
  logic [N_LOC-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0] stat_word, rd_val;

  thr_decode #(.ADDR_W(ADDR_W), .N_OPS(N_OPS), .N_TEST(N_TEST)) i_dec (
    .addr_i    (addr_i),
    .is_cmd_o  (is_cmd),
    .is_stat_o (is_stat),
    .is_store_o(is_store),
    .is_rsvd_o (is_rsvd)
  );

  thr_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EVT_N(EVT_N), .N_LOC(N_LOC)) i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_i && is_store),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .q_o    (regs)
  );

  thr_cmd i_cmd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (wr_i && is_cmd),
    .bits_i   (wdata_i[CMD_W-1:0]),
    .cmd_o    (cmd_o),
    .irq_clr_o(irq_clr)
  );

  assign mask_o = regs[ADR_MASK][EVT_N-1:0];

  thr_irq #(.EVT_N(EVT_N)) i_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt_i),
    .mask_i(mask_o),
    .clr_i (irq_clr),
    .pend_o(pend),
    .irq_o (irq_o)
  );

  always_comb begin
    stat_word              = '0;
    stat_word[EVT_N-1:0]   = pend;
    stat_word[DATA_W-1]    = irq_o;
  end

  always_comb begin
    rd_val = '0;
    if (is_cmd)        rd_val = stk_ptr_i;
    else if (is_stat)  rd_val = stat_word;
    else if (is_store) rd_val = regs[addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
  end

  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_i) |-> $stable(rdata_o));

  assert_rsvd_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i && is_rsvd) |-> (rdata_o == '0));

  assert_stat_summary_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i && is_stat) |-> (rdata_o[DATA_W-1] == (rdata_o[EVT_N-1:0] != '0)));

  assert_ptr_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i && is_cmd) |-> (rdata_o == $past(stk_ptr_i)));
endmodule

// File: tb/test_term_host_regs.sv
module test_term_host_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [15:0] rdata_o;
  logic [15:0] stk_ptr_i = '0;
  logic [14:0] evt_i = '0;
  logic [14:0] mask_o;
  logic [5:0]  cmd_o;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #2 clk_i = ~clk_i;

  term_host_regs i_term_host_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .stk_ptr_i(stk_ptr_i),
    .evt_i(evt_i), .mask_o(mask_o), .cmd_o(cmd_o), .irq_o(irq_o)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compare registered read data against the scoreboard
  always @(posedge clk_i) rd_seen <= rd_i;
  always @(negedge clk_i) begin
    if (rd_seen && exp_q.size() > 0) begin
      automatic logic [15:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(t, rdata_o, e);
    end
  end

  task automatic wr(logic [4:0] a, logic [15:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic [15:0] e, string t);
    addr_i = a; rd_i = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 irq", 16'(irq_o), 16'h0);
    check("R1 cmd", 16'(cmd_o), 16'h0);
    check("R1 rdata", rdata_o, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(5'h01, 16'h0000, "R1 cfg");
    rd(5'h12, 16'h0000, "R1 test");

    // R2 storage
    wr(5'h01, 16'hA5A5);
    wr(5'h04, 16'h1234);
    wr(5'h10, 16'hBEEF);
    wr(5'h17, 16'h0F0F);
    wr(5'h0F, 16'hFFFF);
    rd(5'h01, 16'hA5A5, "R2 0x01");
    rd(5'h04, 16'h1234, "R2 0x04");
    rd(5'h10, 16'hBEEF, "R2 0x10");
    rd(5'h17, 16'h0F0F, "R2 0x17");
    rd(5'h0F, 16'hFFFF, "R2 0x0F");
    wr(5'h00, 16'hFFFF);
    rd(5'h00, 16'h7FFF, "R2 mask width");

    // R5 reserved
    wr(5'h18, 16'h1111);
    wr(5'h1F, 16'h2222);
    rd(5'h18, 16'h0000, "R5 0x18");
    rd(5'h1F, 16'h0000, "R5 0x1F");
    rd(5'h10, 16'hBEEF, "R5 neighbour");

    // R4 pointer read, R3 command pulses
    stk_ptr_i = 16'h02A5;
    rd(5'h03, 16'h02A5, "R4 ptr");
    wr(5'h03, 16'h0002);
    check("R3 start pulse", 16'(cmd_o), 16'h0002);
    @(negedge clk_i);
    check("R3 pulse end", 16'(cmd_o), 16'h0000);
    rd(5'h01, 16'hA5A5, "R4 no store");
    wr(5'h03, 16'hFF30);
    check("R3 stop both", 16'(cmd_o), 16'h0030);
    @(negedge clk_i);
    check("R3 pulse end2", 16'(cmd_o), 16'h0000);

    // R6 / R7 / R8 interrupts
    wr(5'h00, 16'h0005);
    evt_i = 15'h0002; @(negedge clk_i); evt_i = '0;
    check("R6 masked irq", 16'(irq_o), 16'h0);
    rd(5'h06, 16'h0000, "R6 masked stat");
    evt_i = 15'h0004; @(negedge clk_i); evt_i = '0;
    check("R8 irq rise", 16'(irq_o), 16'h1);
    rd(5'h06, 16'h8004, "R7 stat");
    wr(5'h06, 16'h0000);
    rd(5'h06, 16'h8004, "R7 write ignored");

    // R9 clear
    wr(5'h03, 16'h0004);
    check("R9 irq cleared", 16'(irq_o), 16'h0);
    rd(5'h06, 16'h0000, "R9 stat cleared");
    evt_i = 15'h0004; @(negedge clk_i); evt_i = '0;
    // clear and new event on the same edge
    addr_i = 5'h03; wdata_i = 16'h0004; wr_i = 1'b1; evt_i = 15'h0001;
    @(negedge clk_i);
    wr_i = 1'b0; evt_i = '0;
    check("R9 collision irq", 16'(irq_o), 16'h1);
    rd(5'h06, 16'h8001, "R9 collision stat");

    // R10 read during write, hold
    addr_i = 5'h04; wdata_i = 16'h5678; wr_i = 1'b1; rd_i = 1'b1;
    exp_q.push_back(16'h1234); tag_q.push_back("R10 old value");
    @(negedge clk_i);
    wr_i = 1'b0; rd_i = 1'b0;
    addr_i = 5'h10;
    @(negedge clk_i);
    check("R10 hold", rdata_o, 16'h1234);
    rd(5'h04, 16'h5678, "R10 new value");

    repeat (3) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule